// File: doc/BRIEF.md
# Clock Ratio Speed Detector

This block counts how many master-clock cycles fall between consecutive rising edges of an asynchronous frame clock. It matches that count against the ratios a converter accepts and turns the match into a sampling-speed mode code. The converter can then pick its internal rate without any register writes. The frame clock is brought into the master-clock domain through a two-flop synchroniser. A count is accepted when it lies within a small tolerance window around a nominal ratio. A result is only reported, and the lock flag only raised, after several frames in a row have agreed.

The mapping from ratio to mode is not monotonic. Each speed accepts one power-of-two ratio and one ratio that is three halves of it. The slowest speed also accepts 1152. Ratios of 256 and 384 always mean the second speed, even when the frame rate itself would fall in the slowest range. When auto detection is switched off, the mode output simply passes a manual mode input through.

Top module: `clk_ratio_spd_det`

## Requirements
- R1: A synchronous reset (rst_i high at a clock edge) clears lock_o, triple_o and ratio_o, and sets the held mode to Normal (code 0).
- R2: Measured ratios of 512, 768 and 1152 master clocks per frame give mode code 0 (Normal).
- R3: Ratios of 256 and 384 give mode code 1 (Double), even though these ratios also occur at Normal-range frame rates.
- R4: Ratios of 128 and 192 give code 2 (Quad), 64 and 96 give code 3 (Oct), and 32 and 48 give code 4 (Hex).
- R5: While a mode is reported, triple_o is 1 for the ratios 48, 96, 192, 384, 768 and 1152 and 0 for the others, and ratio_o carries the nominal matched ratio.
- R6: A measured period within ±2 cycles of a nominal ratio matches that ratio. A period 3 or more cycles away from every nominal ratio is unsupported.
- R7: A period is measured between consecutive synchronised rising edges. The first edge after reset or after enable only starts the measurement. lock_o rises on the clock after the fourth consecutive measurement with the same classification, and the mode, flag and ratio outputs update at that same clock.
- R8: Lock falls on the clock after any measurement that is unsupported or that differs in classification from the previous one. The mode code, triple flag and ratio keep their last locked values while unlocked.
- R9: A period longer than 2047 cycles saturates the counter and counts as unsupported.
- R10: With auto_en_i low, mode_o follows manual_mode_i, lock_o, triple_o and ratio_o are 0, and measurement restarts from a fresh first edge when auto_en_i returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_i | input | 1 | Synchronous reset, active high |
| frame_i | input | 1 | Frame clock, asynchronous to clk_i |
| auto_en_i | input | 1 | High selects automatic detection |
| manual_mode_i | input | 3 | Mode code used while auto_en_i is low |
| mode_o | output | 3 | Speed code: 0 Normal, 1 Double, 2 Quad, 3 Oct, 4 Hex |
| triple_o | output | 1 | Reported ratio belongs to the three-halves family |
| ratio_o | output | 12 | Nominal reported ratio, 0 after reset |
| lock_o | output | 1 | Classification stable over four frames |

## Verification
The hardest states to reach from the ports are the ones where lock has dropped but the held mode must survive. These are a period just outside the tolerance window, a frame stall long enough to saturate the counter, and a change of ratio family while locked. The stimulus first locks onto a known ratio. It then steps the frame period to exactly two and three cycles off nominal, switches to a different speed for a single frame, and holds the frame clock for 3000 cycles. After each of these, the bench checks that the previously reported mode and ratio are still present. A further sequence drops auto_en_i and raises it again, to show that the first edge afterwards only arms the measurement.

// File: rtl/crsd_pkg.sv
package crsd_pkg;
    // speed codes; numeric values are visible at mode_o
    typedef enum logic [2:0] {
        SPD_NORMAL = 3'd0,
        SPD_DOUBLE = 3'd1,
        SPD_QUAD   = 3'd2,
        SPD_OCT    = 3'd3,
        SPD_HEX    = 3'd4
    } spd_e;

    localparam int NSPD  = 5;            // number of speed codes
    localparam int NCLS  = 2 * NSPD + 1; // two families per speed plus the extra slow ratio
    localparam int CLS_W = $clog2(NCLS);

    typedef struct packed {
        logic             hit;
        spd_e             spd;
        logic             triple;
        logic [CLS_W-1:0] idx;
    } cls_t;
endpackage

// File: rtl/crsd_frame_sync.sv
module crsd_frame_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic frame_i,
    output logic rise_o
);
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d   = {sh_q[STAGES-1:0], frame_i};
        rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) sh_q <= '0;
        else       sh_q <= sh_d;
    end
endmodule

// File: rtl/crsd_period_meter.sv
module crsd_period_meter #(
    parameter int CNT_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic             rise_i,
    output logic             meas_vld_o,
    output logic [CNT_W-1:0] meas_cnt_o,
    output logic             meas_sat_o
);
    localparam logic [CNT_W-1:0] SAT_VAL = CNT_W'(1) << (CNT_W - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        meas_vld_o = en_i & rise_i & st_q.armed;
        meas_cnt_o = st_q.cnt;
        meas_sat_o = (st_q.cnt >= SAT_VAL);
        if (!en_i) begin
            st_d.cnt   = '0;
            st_d.armed = 1'b0;
        end else if (rise_i) begin
            st_d.cnt   = CNT_W'(1);
            st_d.armed = 1'b1;
        end else if (st_q.cnt != SAT_VAL) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end
endmodule

// File: rtl/crsd_ratio_classify.sv
module crsd_ratio_classify
    import crsd_pkg::*;
#(
    parameter int CNT_W       = 12,
    parameter int BASE_RATIO  = 32,
    parameter int TOL         = 2,
    parameter int EXTRA_RATIO = 1152
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             sat_i,
    output cls_t             cls_o,
    output logic [CNT_W-1:0] nom_o
);
    function automatic int nom_of(input int k, input int fam);
        return (fam == 1) ? ((BASE_RATIO * 3 / 2) << k) : (BASE_RATIO << k);
    endfunction

    function automatic logic in_win(input logic [CNT_W-1:0] c, input int n);
        int ci;
        ci = int'(c);
        return (ci >= n - TOL) && (ci <= n + TOL);
    endfunction

    always_comb begin
        cls_o     = '0;
        cls_o.spd = SPD_NORMAL;
        nom_o     = '0;
        // k = 0 is the fastest speed (smallest ratio)
        for (int k = 0; k < NSPD; k++) begin
            for (int fam = 0; fam < 2; fam++) begin
                if (!cls_o.hit && !sat_i && in_win(cnt_i, nom_of(k, fam))) begin
                    cls_o.hit    = 1'b1;
                    cls_o.spd    = spd_e'(NSPD - 1 - k);
                    cls_o.triple = (fam == 1);
                    cls_o.idx    = CLS_W'(2 * k + fam);
                    nom_o        = CNT_W'(nom_of(k, fam));
                end
            end
        end
        if (!cls_o.hit && !sat_i && in_win(cnt_i, EXTRA_RATIO)) begin
            cls_o.hit    = 1'b1;
            cls_o.spd    = SPD_NORMAL;
            cls_o.triple = 1'b1;
            cls_o.idx    = CLS_W'(NCLS - 1);
            nom_o        = CNT_W'(EXTRA_RATIO);
        end
    end
endmodule

// File: rtl/crsd_lock_filter.sv
module crsd_lock_filter
    import crsd_pkg::*;
#(
    parameter int LOCK_FRAMES = 4,
    parameter int RATIO_W     = 12
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               en_i,
    input  logic               meas_vld_i,
    input  cls_t               cls_i,
    input  logic [RATIO_W-1:0] nom_i,
    output logic               lock_o,
    output spd_e               mode_o,
    output logic               triple_o,
    output logic [RATIO_W-1:0] ratio_o
);
    localparam int RUN_W = $clog2(LOCK_FRAMES + 1);
    localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(LOCK_FRAMES);

    typedef struct packed {
        logic [RUN_W-1:0]   run;
        logic               have;
        logic [CLS_W-1:0]   prev;
        logic               lock;
        spd_e               mode;
        logic               triple;
        logic [RATIO_W-1:0] ratio;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en_i) begin
            st_d.run  = '0;
            st_d.have = 1'b0;
            st_d.lock = 1'b0;
        end else if (meas_vld_i) begin
            if (!cls_i.hit) begin
                st_d.run  = '0;
                st_d.have = 1'b0;
                st_d.lock = 1'b0;
            end else if (st_q.have && (cls_i.idx == st_q.prev)) begin
                if (st_q.run != RUN_FULL) st_d.run = st_q.run + RUN_W'(1);
            end else begin
                st_d.run  = RUN_W'(1);
                st_d.have = 1'b1;
                st_d.prev = cls_i.idx;
                st_d.lock = 1'b0;
            end
            if (cls_i.hit && (st_d.run == RUN_FULL)) begin
                st_d.lock   = 1'b1;
                st_d.mode   = cls_i.spd;
                st_d.triple = cls_i.triple;
                st_d.ratio  = nom_i;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q      <= '0;
            st_q.mode <= SPD_NORMAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign lock_o   = st_q.lock;
    assign mode_o   = st_q.mode;
    assign triple_o = st_q.triple;
    assign ratio_o  = st_q.ratio;
endmodule

// File: rtl/clk_ratio_spd_det.sv
module clk_ratio_spd_det
    import crsd_pkg::*;
#(
    parameter int CNT_W       = 12,
    parameter int SYNC_STAGES = 2,
    parameter int BASE_RATIO  = 32,
    parameter int TOL         = 2,
    parameter int EXTRA_RATIO = 1152,
    parameter int LOCK_FRAMES = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             frame_i,
    input  logic             auto_en_i,
    input  logic [2:0]       manual_mode_i,
    output logic [2:0]       mode_o,
    output logic             triple_o,
    output logic [CNT_W-1:0] ratio_o,
    output logic             lock_o
);
    logic             rise;
    logic             m_vld;
    logic             m_sat;
    logic [CNT_W-1:0] m_cnt;
    cls_t             cls;
    logic             c_hit;
    logic [CNT_W-1:0] c_nom;
    logic             fl_lock;
    spd_e             fl_spd;
    logic [2:0]       fl_mode;
    logic             fl_triple;
    logic [CNT_W-1:0] fl_ratio;

    crsd_frame_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i(clk_i), .rst_i(rst_i), .frame_i(frame_i), .rise_o(rise)
    );

    crsd_period_meter #(.CNT_W(CNT_W)) u_meter (
        .clk_i(clk_i), .rst_i(rst_i), .en_i(auto_en_i), .rise_i(rise),
        .meas_vld_o(m_vld), .meas_cnt_o(m_cnt), .meas_sat_o(m_sat)
    );

    crsd_ratio_classify #(
        .CNT_W(CNT_W), .BASE_RATIO(BASE_RATIO), .TOL(TOL), .EXTRA_RATIO(EXTRA_RATIO)
    ) u_cls (
        .cnt_i(m_cnt), .sat_i(m_sat), .cls_o(cls), .nom_o(c_nom)
    );

    crsd_lock_filter #(.LOCK_FRAMES(LOCK_FRAMES), .RATIO_W(CNT_W)) u_filt (
        .clk_i(clk_i), .rst_i(rst_i), .en_i(auto_en_i), .meas_vld_i(m_vld),
        .cls_i(cls), .nom_i(c_nom), .lock_o(fl_lock), .mode_o(fl_spd),
        .triple_o(fl_triple), .ratio_o(fl_ratio)
    );

    assign c_hit   = cls.hit;
    assign fl_mode = 3'(fl_spd);

    always_comb begin
        mode_o   = auto_en_i ? fl_mode : manual_mode_i;
        triple_o = auto_en_i & fl_triple;
        ratio_o  = auto_en_i ? fl_ratio : '0;
        lock_o   = auto_en_i & fl_lock;
    end
endmodule

// File: rtl/crsd_checker.sv
module crsd_checker (
    input logic       clk_i,
    input logic       rst_i,
    input logic       auto_en_i,
    input logic       m_vld,
    input logic       m_sat,
    input logic       c_hit,
    input logic       fl_lock,
    input logic [2:0] fl_mode
);
    // R1: reset leaves the filter unlocked at Normal
    a_r1_reset_clears: assert property (@(posedge clk_i)
        rst_i |=> (!fl_lock && fl_mode == 3'd0));

    // R7: lock can only rise right after a supported measurement
    a_r7_lock_after_meas: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(fl_lock) |-> ($past(m_vld) && $past(c_hit)));

    // R8: the held mode never moves while unlocked unless lock is taken again
    a_r8_mode_held: assert property (@(posedge clk_i) disable iff (rst_i)
        !fl_lock |=> (fl_lock || $stable(fl_mode)));

    // R8: an unsupported measurement drops lock on the next clock
    a_r8_drop_on_bad: assert property (@(posedge clk_i) disable iff (rst_i)
        (m_vld && !c_hit) |=> !fl_lock);

    // R9: a saturated period never classifies
    a_r9_sat_unsupported: assert property (@(posedge clk_i) disable iff (rst_i)
        (m_vld && m_sat) |-> !c_hit);

    // R10: disabling auto detection clears the lock state
    a_r10_auto_off_unlocks: assert property (@(posedge clk_i) disable iff (rst_i)
        !auto_en_i |=> !fl_lock);
endmodule

bind clk_ratio_spd_det crsd_checker u_chk (
    .clk_i(clk_i), .rst_i(rst_i), .auto_en_i(auto_en_i), .m_vld(m_vld),
    .m_sat(m_sat), .c_hit(c_hit), .fl_lock(fl_lock), .fl_mode(fl_mode)
);

// File: tb/sim_clk_ratio_spd_det.sv
module sim_clk_ratio_spd_det;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_i = 1'b1;
    logic        frame_i = 1'b0;
    logic        auto_en_i = 1'b1;
    logic [2:0]  manual_mode_i = 3'd0;
    logic [2:0]  mode_o;
    logic        triple_o;
    logic [11:0] ratio_o;
    logic        lock_o;

    clk_ratio_spd_det u0 (
        .clk_i(clk), .rst_i(rst_i), .frame_i(frame_i), .auto_en_i(auto_en_i),
        .manual_mode_i(manual_mode_i), .mode_o(mode_o), .triple_o(triple_o),
        .ratio_o(ratio_o), .lock_o(lock_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // stimulus for the next edge
    logic       g_rst = 1'b1;
    logic       g_auto = 1'b1;
    logic [2:0] g_man = 3'd0;

    // reference model state
    int m_s1 = 0, m_s2 = 0, m_s3 = 0;
    int m_cnt = 0, m_armed = 0, m_run = 0, m_prev = -1;
    int m_lock = 0, m_mode = 0, m_trp = 0, m_ratio = 0;

    int noms[11] = '{1152, 768, 512, 384, 256, 192, 128, 96, 64, 48, 32};
    int spds[11] = '{0, 0, 0, 1, 1, 2, 2, 3, 3, 4, 4};
    int trps[11] = '{1, 1, 0, 1, 0, 1, 0, 1, 0, 1, 0};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int classify(input int c);
        if (c >= 2048) return -1;
        for (int i = 0; i < 11; i++)
            if (c >= noms[i] - 2 && c <= noms[i] + 2) return i;
        return -1;
    endfunction

    task automatic model_update();
        int rise, k;
        if (rst_i) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_cnt = 0; m_armed = 0; m_run = 0;
            m_prev = -1; m_lock = 0; m_mode = 0; m_trp = 0; m_ratio = 0;
            return;
        end
        rise = (m_s2 == 1 && m_s3 == 0);
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(frame_i);
        if (!auto_en_i) begin
            m_cnt = 0; m_armed = 0; m_run = 0; m_prev = -1; m_lock = 0;
        end else if (rise) begin
            if (m_armed) begin
                k = classify(m_cnt);
                if (k < 0) begin
                    m_run = 0; m_prev = -1; m_lock = 0;
                end else if (k == m_prev) begin
                    if (m_run < 4) m_run++;
                end else begin
                    m_run = 1; m_prev = k; m_lock = 0;
                end
                if (k >= 0 && m_run == 4) begin
                    m_lock = 1; m_mode = spds[k]; m_trp = trps[k]; m_ratio = noms[k];
                end
            end
            m_cnt = 1; m_armed = 1;
        end else if (m_cnt < 2048) begin
            m_cnt++;
        end
    endtask

    task automatic step(input logic f);
        @(negedge clk);
        // per-cycle comparison against the model
        chk("R7 lock", lock_o, auto_en_i ? m_lock : 0);
        chk("R4 mode", mode_o, auto_en_i ? m_mode : int'(manual_mode_i));
        chk("R5 triple", triple_o, auto_en_i ? m_trp : 0);
        chk("R5 ratio", ratio_o, auto_en_i ? m_ratio : 0);
        rst_i = g_rst; auto_en_i = g_auto; manual_mode_i = g_man; frame_i = f;
        model_update();
    endtask

    task automatic run_frames(input int p, input int n);
        for (int i = 0; i < n; i++)
            for (int c = 0; c < p; c++)
                step(c < p / 2);
    endtask

    task automatic expect_out(input string tag, input int md, input int tp, input int rt, input int lk);
        chk({tag, " mode"}, mode_o, md);
        chk({tag, " triple"}, triple_o, tp);
        chk({tag, " ratio"}, ratio_o, rt);
        chk({tag, " lock"}, lock_o, lk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL R7 watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) step(1'b0);
        g_rst = 1'b0;
        step(1'b0);
        expect_out("R1", 0, 0, 0, 0);

        run_frames(512, 6);  expect_out("R2", 0, 0, 512, 1);
        run_frames(768, 6);  expect_out("R2", 0, 1, 768, 1);
        run_frames(1152, 6); expect_out("R2", 0, 1, 1152, 1);
        run_frames(256, 6);  expect_out("R3", 1, 0, 256, 1);
        run_frames(384, 6);  expect_out("R3", 1, 1, 384, 1);
        run_frames(192, 6);  expect_out("R4", 2, 1, 192, 1);
        run_frames(96, 6);   expect_out("R4", 3, 1, 96, 1);
        run_frames(64, 6);   expect_out("R4", 3, 0, 64, 1);
        run_frames(48, 6);   expect_out("R5", 4, 1, 48, 1);
        run_frames(32, 6);   expect_out("R4", 4, 0, 32, 1);

        // tolerance window around 128
        run_frames(130, 6);  expect_out("R6", 2, 0, 128, 1);
        run_frames(131, 3);  expect_out("R6", 2, 0, 128, 0);
        run_frames(126, 6);  expect_out("R6", 2, 0, 128, 1);

        // change of classification while locked
        run_frames(256, 2);  expect_out("R8", 2, 0, 128, 0);
        run_frames(64, 6);   expect_out("R8", 3, 0, 64, 1);

        // stalled frame clock saturates the counter
        run_frames(3000, 2); expect_out("R9", 3, 0, 64, 0);

        // manual mode
        g_auto = 1'b0; g_man = 3'd6;
        for (int i = 0; i < 20; i++) step(1'b0);
        expect_out("R10", 6, 0, 0, 0);
        g_auto = 1'b1;
        run_frames(48, 2);   expect_out("R10", 3, 0, 64, 0);
        run_frames(48, 4);   expect_out("R10", 4, 1, 48, 1);

        // reset while locked
        g_rst = 1'b1;
        for (int i = 0; i < 3; i++) step(1'b0);
        g_rst = 1'b0;
        step(1'b0);
        expect_out("R1", 0, 0, 0, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule